// File: doc/BRIEF.md
# Flash Status Register Unit

This block keeps the 8-bit status byte of a flash-style command interface and owns the read path that presents it. A command decoder upstream supplies one-cycle strobes for four command classes: status read, status clear, array read, and everything else. An embedded program/erase sequencer supplies per-bit set and clear pulses. Chip-enable and output-enable arrive as synchronous active-low strobes, sampled on the system clock.

The read path is in one of two modes. In array mode the array data passes straight through. In status mode the output carries a snapshot of the status byte. The snapshot is taken on the clock edge where the read first becomes active, which is the later of the two strobe falls. It then stays frozen until a strobe goes high again. Bits 4 and 5 are sticky error flags. The sequencer can raise them, but only the host's clear command lowers them. While either flag is up, the command-accept mask refuses every command except the three status and read commands.

Top module: `flash_status_unit`

## Requirements
- R1: After reset the status byte is 00h, the snapshot is 00h, the read path is in array mode (rd_data equals array_data), and cmd_accept is 4'b1111.
- R2: A status-read strobe puts the read path in status mode. rd_data[7:0] then shows the snapshot. Only an array-read strobe returns it to array mode. Status-clear and other-command strobes leave the mode unchanged.
- R3: For bits 0-3, 6 and 7, a set pulse raises the bit and a clear pulse lowers it at the next clock edge. When both pulses arrive in the same cycle, the set wins.
- R4: Bits 4 and 5 can be raised by the sequencer. Sequencer clear pulses have no effect on them.
- R5: cmd_accept bit order is {other, clear, status-read, array-read}, with bit 3 being "other". Bit 3 is 0 while status bit 4 or bit 5 is 1. Bits 2..0 are always 1.
- R6: The snapshot is taken at the first clock edge where ce_n and oe_n are both sampled low. It holds the status value from before that edge, so a strobe that falls late picks up changes made while the other strobe was already low.
- R7: While both strobes stay low, rd_data does not change even if the status changes. A new value appears only after a strobe goes high and falls again.
- R8: hi_oe equals word_mode. In status mode rd_data[15:8] is 00h.
- R9: A status-clear strobe clears bits 4 and 5 at the next edge, so cmd_accept[3] returns to 1 in the cycle after the strobe. A sequencer set on bit 4 or 5 in that same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_rd_status | input | 1 | Status-read command strobe |
| cmd_clr_status | input | 1 | Status-clear command strobe |
| cmd_rd_array | input | 1 | Array-read command strobe |
| cmd_other | input | 1 | Strobe for any other command |
| sm_set | input | 8 | Per-bit set pulses from the sequencer |
| sm_clr | input | 8 | Per-bit clear pulses from the sequencer |
| ce_n | input | 1 | Chip enable, active low, synchronous |
| oe_n | input | 1 | Output enable, active low, synchronous |
| word_mode | input | 1 | 1 selects 16-bit bus width, 0 selects byte width |
| array_data | input | 16 | Data from the memory array |
| rd_data | output | 16 | Read data toward the pads |
| hi_oe | output | 1 | Drive enable for rd_data[15:8] |
| cmd_accept | output | 4 | Command-accept mask, one bit per command class |

## Verification
The assertions assume that the decoder raises at most one command strobe per cycle and that each strobe lasts one cycle. The stimulus honours this because every command goes through a single task that pulses one strobe and then drops it. The assertions also assume the strobes are synchronous to clk. The bench meets this by changing ce_n and oe_n shortly after a rising edge and reading results at the falling edge. Sequencer pulses are kept one cycle wide, with set and clear overlapping only in the cases that test set priority.

// File: rtl/flash_status_unit.sv
module flash_status_unit #(
  parameter int          STAT_W = 8,
  parameter int          DATA_W = 16,
  parameter logic [7:0]  STICKY = 8'h30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_rd_status,
  input  logic              cmd_clr_status,
  input  logic              cmd_rd_array,
  input  logic              cmd_other,
  input  logic [STAT_W-1:0] sm_set,
  input  logic [STAT_W-1:0] sm_clr,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              word_mode,
  input  logic [DATA_W-1:0] array_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              hi_oe,
  output logic [3:0]        cmd_accept
);
  localparam int PAD_W = DATA_W - STAT_W;

  logic [STAT_W-1:0] stat_q, snap_q, stat_d;
  logic              stat_mode, act_q;

  wire rd_act = ~ce_n & ~oe_n;
  wire err    = |(stat_q & STICKY);

  always_comb begin
    stat_d = stat_q & ~(sm_clr & ~STICKY);
    if (cmd_clr_status) stat_d = stat_d & ~STICKY;
    stat_d = stat_d | sm_set;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q    <= '0;
      snap_q    <= '0;
      stat_mode <= 1'b0;
      act_q     <= 1'b0;
    end else begin
      stat_q <= stat_d;
      act_q  <= rd_act;
      if (rd_act && !act_q) snap_q <= stat_q;
      if (cmd_rd_status)     stat_mode <= 1'b1;
      else if (cmd_rd_array) stat_mode <= 1'b0;
    end
  end

  assign rd_data    = stat_mode ? {{PAD_W{1'b0}}, snap_q} : array_data;
  assign hi_oe      = word_mode;
  assign cmd_accept = {~err, 3'b111};

  assert_one_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_rd_status, cmd_clr_status, cmd_rd_array, cmd_other}));

  assert_mode_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_other || cmd_clr_status) |=> $stable(stat_mode));

  assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_clr_status |=> ((stat_q & STICKY & $past(stat_q)) == ($past(stat_q) & STICKY)));

  assert_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_act && act_q) |=> $stable(snap_q));

  assert_unlock_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_clr_status && ((sm_set & STICKY) == '0)) |=> !err);
endmodule

// File: tb/flash_status_unit_test.sv
module flash_status_unit_test;
  logic clk = 0, rst_n = 0;
  logic cmd_rd_status = 0, cmd_clr_status = 0, cmd_rd_array = 0, cmd_other = 0;
  logic [7:0] sm_set = 0, sm_clr = 0;
  logic ce_n = 1, oe_n = 1, word_mode = 1;
  logic [15:0] array_data = 16'hA55A;
  logic [15:0] rd_data;
  logic hi_oe;
  logic [3:0] cmd_accept;

  int errors = 0, checks = 0;
  bit done = 0, smp = 0;
  logic [15:0] q_exp[$];
  string q_tag[$];
  logic [7:0] model = 0;

  always #10 clk = ~clk;

  flash_status_unit uut (.*);

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic chk(input logic [15:0] got, input logic [15:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // driver: push the expected word, monitor compares at the falling edge
  task automatic expect_rd(input logic [15:0] exp, input string tag);
    q_exp.push_back(exp);
    q_tag.push_back(tag);
    smp = 1;
    step();
    smp = 0;
  endtask

  task automatic read_once(input logic [15:0] exp, input string tag);
    ce_n = 0; oe_n = 0;
    step();
    expect_rd(exp, tag);
    ce_n = 1; oe_n = 1;
    step();
  endtask

  task automatic cmd(input int k);
    case (k)
      0: cmd_rd_array = 1;
      1: cmd_rd_status = 1;
      2: cmd_clr_status = 1;
      default: cmd_other = 1;
    endcase
    step();
    {cmd_rd_array, cmd_rd_status, cmd_clr_status, cmd_other} = 0;
  endtask

  task automatic sm(input logic [7:0] s, input logic [7:0] c);
    sm_set = s; sm_clr = c;
    step();
    sm_set = 0; sm_clr = 0;
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (smp && q_exp.size() > 0) chk(rd_data, q_exp.pop_front(), q_tag.pop_front());
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    step(); step();
    rst_n = 1;
    step();
    // R1 reset state
    chk({12'h0, cmd_accept}, 16'h000F, "R1 accept after reset");
    read_once(16'hA55A, "R1 array mode after reset");
    chk({15'h0, hi_oe}, 16'h0001, "R8 hi_oe word mode");
    cmd(1);
    read_once(16'h0000, "R1 status 00 after reset");
    // R3 set / clear / priority
    sm(8'h81, 8'h00); model = 8'h81;
    read_once({8'h00, model}, "R3 set bits 0 and 7");
    sm(8'h00, 8'h01); model = 8'h80;
    read_once({8'h00, model}, "R3 clear bit 0");
    sm(8'h02, 8'h02); model = 8'h82;
    read_once({8'h00, model}, "R3 set wins over clear");
    // R4 / R5 sticky error and lockout
    sm(8'h10, 8'h00); model = 8'h92;
    chk({12'h0, cmd_accept}, 16'h0007, "R5 other refused while bit4 set");
    sm(8'h00, 8'h30);
    read_once({8'h00, model}, "R4 sequencer clear ignored on bit4");
    cmd(3);
    read_once({8'h00, model}, "R2 other command keeps status mode");
    // R7 freeze while both strobes low
    ce_n = 0; oe_n = 0;
    step();
    expect_rd({8'h00, model}, "R6 capture on read start");
    sm(8'h40, 8'h00); model = 8'hD2;
    step();
    chk(rd_data, 16'h0092, "R7 frozen while strobes held low");
    oe_n = 1; step();
    oe_n = 0; step();
    expect_rd({8'h00, model}, "R7 new value after oe toggle");
    ce_n = 1; oe_n = 1; step();
    // R6 later falling strobe decides the capture
    ce_n = 0; step(); step();
    sm(8'h08, 8'h00); model = 8'hDA;
    oe_n = 0; step();
    expect_rd({8'h00, model}, "R6 late oe fall picks up new bit");
    ce_n = 1; oe_n = 1; step();
    // R9 clear status ends lockout next cycle
    cmd(2); model = model & 8'hCF;
    chk({12'h0, cmd_accept}, 16'h000F, "R9 accept restored after clear");
    read_once({8'h00, model}, "R9 bits 4 and 5 cleared");
    sm(8'h20, 8'h00); model = model | 8'h20;
    chk({12'h0, cmd_accept}, 16'h0007, "R5 other refused while bit5 set");
    sm_set = 8'h20; cmd_clr_status = 1; step();
    sm_set = 0; cmd_clr_status = 0;
    chk({12'h0, cmd_accept}, 16'h0007, "R9 set beats clear command");
    cmd(2); model = model & 8'hCF;
    // R8 byte mode
    word_mode = 0; step();
    chk({15'h0, hi_oe}, 16'h0000, "R8 hi_oe byte mode");
    read_once({8'h00, model}, "R8 status upper byte zero");
    // R2 array read returns to array data
    cmd(2);
    read_once({8'h00, model}, "R2 clear keeps status mode");
    array_data = 16'h3C7E;
    cmd(0);
    read_once(16'h3C7E, "R2 array read restores array data");
    step(); step();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule